// File: doc/BRIEF.md
# Programmable 32-Source Interrupt Controller

This block gathers 32 interrupt request lines and turns them into two processor-facing interrupt outputs: a normal one and a critical one. Each line is first brought into the controller's clock domain. It is then qualified as level or edge sensitive, with a chosen active sense. A qualified event latches a pending bit. Software reads and writes a small register set over a plain address, data and write-strobe port. Through that port it unmasks sources, steers each one to the normal or the critical output, and acknowledges pending bits by writing ones.

Sources are numbered from the most significant end. Source n lives at register bit 31-n. The controller also reports the lowest-numbered source that is both pending and unmasked, so that a handler or a parent controller in a cascade can pick the next source without scanning the word itself.

Top module: `pirq_ctrl`

## Requirements
- R1: Source n (input `src_in[n]`) appears at bit 31-n of every per-source register. For example, source 3 is bit 28 and source 0 is bit 31.
- R2: After reset, the registers read as follows: enable (offset 0x2), critical select (0x3) and trigger (0x5) are zero; sense (0x4) is all ones; pending status (0x0) is zero while no input is active. `norm_irq`, `crit_irq` and `pend_valid` are low.
- R3: An edge source (trigger bit 1) with sense bit 1 latches its pending bit on a rising input. The bit stays set after the input falls.
- R4: An edge source with sense bit 0 latches on a falling input and not on a rising one.
- R5: A level source (trigger bit 0) sets its pending bit while its input is at the active sense. A write-one acknowledge leaves the bit set while the input stays active, enabled or not. Once the input is inactive, the bit stays latched until it is acknowledged.
- R6: Writing to offset 0x0 clears each pending bit written as 1 and leaves each bit written as 0 unchanged.
- R7: When an edge is detected in the same cycle as an acknowledge of that source, the pending bit stays set.
- R8: Offset 0x6 reads the bitwise AND of pending status and enable.
- R9: `crit_irq` is the registered OR of unmasked pending bits whose critical-select bit is 1. `norm_irq` is the registered OR of those whose critical-select bit is 0. Each updates one clock after the masked status.
- R10: `pend_valid` is high when any unmasked bit is pending. `pend_src` then gives the lowest-numbered such source, which is the most significant set bit of the masked status.
- R11: Offsets that hold no register (including 0x1, 0x7 and 0x8) read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | 32 | Raw interrupt lines, index n is source n |
| bus_addr | input | 4 | Register word offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| norm_irq | output | 1 | Normal interrupt request |
| crit_irq | output | 1 | Critical interrupt request |
| pend_valid | output | 1 | Some unmasked source is pending |
| pend_src | output | 5 | Lowest-numbered unmasked pending source |

## Verification
A held-high line on a level source separates latching from following the input, and shows that an acknowledge cannot remove a still-active level request. Short pulses on edge sources, under both senses, separate true edge capture from level capture. A rising pulse under falling sense must leave nothing pending. An acknowledge timed to land on the same clock as a fresh edge shows the set-over-clear priority. Two sources enabled at once, one of them steered critical, show the output routing and the lowest-number priority. Masking the winner then moves `pend_src` to the other source.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  localparam int NSRC  = 32;
  localparam int IDX_W = $clog2(NSRC);

  localparam logic [3:0] OFS_STATUS = 4'h0;
  localparam logic [3:0] OFS_ENABLE = 4'h2;
  localparam logic [3:0] OFS_CRIT   = 4'h3;
  localparam logic [3:0] OFS_SENSE  = 4'h4;
  localparam logic [3:0] OFS_TRIG   = 4'h5;
  localparam logic [3:0] OFS_MASKED = 4'h6;

  // Raw line after sense adjustment: 1 means "active".
  function automatic logic [NSRC-1:0] sense_adjust(input logic [NSRC-1:0] lvl,
                                                   input logic [NSRC-1:0] sense);
    return ~(lvl ^ sense);
  endfunction

  // Lowest source number with its bit set; source n lives at bit NSRC-1-n.
  function automatic logic [IDX_W-1:0] first_src(input logic [NSRC-1:0] vec);
    logic [IDX_W-1:0] idx;
    idx = '0;
    for (int n = NSRC - 1; n >= 0; n--) begin
      if (vec[NSRC-1-n]) idx = IDX_W'(n);
    end
    return idx;
  endfunction
endpackage

// File: rtl/pirq_sync.sv
module pirq_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[s] <= '0;
        else if (s == 0) stage[s] <= d;
        else stage[s] <= stage[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = stage[STAGES-1];
endmodule

// File: rtl/pirq_detect.sv
module pirq_detect
  import pirq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] lvl,
  input  logic [NSRC-1:0] sense,
  input  logic [NSRC-1:0] trig,
  output logic [NSRC-1:0] edge_hit,
  output logic [NSRC-1:0] set_vec
);
  logic [NSRC-1:0] active;
  logic [NSRC-1:0] prev_q;

  assign active = sense_adjust(lvl, sense);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else prev_q <= active;
  end

  assign edge_hit = active & ~prev_q;
  assign set_vec  = (trig & edge_hit) | (~trig & active);
endmodule

// File: rtl/pirq_status.sv
module pirq_status
  import pirq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_vec,
  input  logic [NSRC-1:0] clr_vec,
  output logic [NSRC-1:0] status_q
);
  // Set has priority over a same-cycle acknowledge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else status_q <= set_vec | (status_q & ~clr_vec);
  end
endmodule

// File: rtl/pirq_ctrl.sv
module pirq_ctrl
  import pirq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_in,
  input  logic [3:0]       bus_addr,
  input  logic             bus_wr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic             norm_irq,
  output logic             crit_irq,
  output logic             pend_valid,
  output logic [IDX_W-1:0] pend_src
);
  logic [NSRC-1:0] src_bits;
  logic [NSRC-1:0] lvl_sync;
  logic [NSRC-1:0] edge_hit;
  logic [NSRC-1:0] set_vec;
  logic [NSRC-1:0] clr_vec;
  logic [NSRC-1:0] status_q;
  logic [NSRC-1:0] enable_q;
  logic [NSRC-1:0] crit_q;
  logic [NSRC-1:0] sense_q;
  logic [NSRC-1:0] trig_q;
  logic [NSRC-1:0] masked;

  // Source n -> register bit NSRC-1-n
  generate
    for (genvar n = 0; n < NSRC; n++) begin : g_map
      assign src_bits[NSRC-1-n] = src_in[n];
    end
  endgenerate

  pirq_sync #(.W(NSRC), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(src_bits), .q(lvl_sync)
  );

  pirq_detect u_det (
    .clk(clk), .rst_n(rst_n), .lvl(lvl_sync), .sense(sense_q),
    .trig(trig_q), .edge_hit(edge_hit), .set_vec(set_vec)
  );

  assign clr_vec = (bus_wr && bus_addr == OFS_STATUS) ? bus_wdata[NSRC-1:0] : '0;

  pirq_status u_stat (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec), .status_q(status_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q <= '0;
      crit_q   <= '0;
      sense_q  <= '1;
      trig_q   <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        OFS_ENABLE: enable_q <= bus_wdata[NSRC-1:0];
        OFS_CRIT:   crit_q   <= bus_wdata[NSRC-1:0];
        OFS_SENSE:  sense_q  <= bus_wdata[NSRC-1:0];
        OFS_TRIG:   trig_q   <= bus_wdata[NSRC-1:0];
        default: ;
      endcase
    end
  end

  assign masked = status_q & enable_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      norm_irq <= 1'b0;
      crit_irq <= 1'b0;
    end else begin
      norm_irq <= |(masked & ~crit_q);
      crit_irq <= |(masked & crit_q);
    end
  end

  assign pend_valid = |masked;
  assign pend_src   = first_src(masked);

  always_comb begin
    case (bus_addr)
      OFS_STATUS: bus_rdata = status_q;
      OFS_ENABLE: bus_rdata = enable_q;
      OFS_CRIT:   bus_rdata = crit_q;
      OFS_SENSE:  bus_rdata = sense_q;
      OFS_TRIG:   bus_rdata = trig_q;
      OFS_MASKED: bus_rdata = masked;
      default:    bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/pirq_check.sv
module pirq_check
  import pirq_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [3:0]       bus_addr,
  input logic [31:0]      bus_rdata,
  input logic             norm_irq,
  input logic             crit_irq,
  input logic             pend_valid,
  input logic [IDX_W-1:0] pend_src,
  input logic [NSRC-1:0]  set_vec,
  input logic [NSRC-1:0]  clr_vec,
  input logic [NSRC-1:0]  status_q,
  input logic [NSRC-1:0]  enable_q,
  input logic [NSRC-1:0]  crit_q
);
  logic [NSRC-1:0] mk;
  assign mk = status_q & enable_q;

  // R7: every requested set is present one cycle later, even under a clear
  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & $past(set_vec)) == $past(set_vec)));

  // R6: a bit that was neither cleared nor set survives
  assert_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & $past(status_q & ~clr_vec)) == $past(status_q & ~clr_vec)));

  // R6: a bit only becomes set by a set request
  assert_no_spurious_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & ~$past(status_q) & ~$past(set_vec)) == '0));

  assert_masked_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == OFS_MASKED) |-> (bus_rdata == mk));

  assert_crit_out_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (crit_irq == $past(|(mk & crit_q))));

  assert_norm_out_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (norm_irq == $past(|(mk & ~crit_q))));

  assert_pend_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pend_valid == (mk != '0));

  assert_pend_hit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pend_valid |-> mk[NSRC-1-int'(pend_src)]);

  assert_pend_lowest_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pend_valid |-> ((mk & ~({NSRC{1'b1}} >> pend_src)) == '0));
endmodule

bind pirq_ctrl pirq_check u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .norm_irq(norm_irq), .crit_irq(crit_irq), .pend_valid(pend_valid),
  .pend_src(pend_src), .set_vec(set_vec), .clr_vec(clr_vec),
  .status_q(status_q), .enable_q(enable_q), .crit_q(crit_q)
);

// File: tb/pirq_ctrl_bench.sv
module pirq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_in = '0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        norm_irq, crit_irq, pend_valid;
  logic [4:0]  pend_src;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  pirq_ctrl u_pirq_ctrl (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .norm_irq(norm_irq), .crit_irq(crit_irq), .pend_valid(pend_valid),
    .pend_src(pend_src)
  );

  // Bench's own view of the numbering: source n at bit 31-n
  function automatic logic [31:0] bit_of(input int n);
    return 32'h8000_0000 >> n;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_addr = a;
    #1;
    chk(req, bus_rdata, exp);
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset();
    rd_chk("R2 status",  4'h0, 32'h0);
    rd_chk("R2 enable",  4'h2, 32'h0);
    rd_chk("R2 crit",    4'h3, 32'h0);
    rd_chk("R2 sense",   4'h4, 32'hFFFF_FFFF);
    rd_chk("R2 trig",    4'h5, 32'h0);
    chk("R2 outputs", {29'd0, norm_irq, crit_irq, pend_valid}, 32'h0);
  endtask

  task automatic t_level();
    @(negedge clk); src_in[3] = 1'b1;
    settle();
    rd_chk("R1 source 3 at bit 28", 4'h0, bit_of(3));
    wr(4'h0, bit_of(3));
    rd_chk("R5 ack ignored while active (disabled)", 4'h0, bit_of(3));
    wr(4'h2, bit_of(3));
    wr(4'h0, bit_of(3));
    rd_chk("R5 ack ignored while active (enabled)", 4'h0, bit_of(3));
    rd_chk("R8 masked status", 4'h6, bit_of(3));
    settle();
    chk("R9 normal output", {30'd0, norm_irq, crit_irq}, 32'h2);
    chk("R10 pending source 3", {26'd0, pend_valid, pend_src}, {26'd0, 1'b1, 5'd3});
    @(negedge clk); src_in[3] = 1'b0;
    settle();
    rd_chk("R5 latched after input drops", 4'h0, bit_of(3));
    wr(4'h0, bit_of(3));
    rd_chk("R5 ack clears inactive level", 4'h0, 32'h0);
    wr(4'h2, 32'h0);
  endtask

  task automatic t_edge();
    wr(4'h5, bit_of(7));
    @(negedge clk); src_in[7] = 1'b1;
    repeat (2) @(negedge clk); src_in[7] = 1'b0;
    settle();
    rd_chk("R3 rising edge latched after pulse", 4'h0, bit_of(7));
    wr(4'h0, 32'h0);
    rd_chk("R6 write zero leaves bit", 4'h0, bit_of(7));
    wr(4'h0, bit_of(7));
    rd_chk("R6 write one clears", 4'h0, 32'h0);
  endtask

  task automatic t_fall();
    wr(4'h5, bit_of(7) | bit_of(10));
    @(negedge clk); src_in[10] = 1'b1;
    settle();
    wr(4'h4, ~bit_of(10));
    settle();
    wr(4'h0, bit_of(10));
    rd_chk("R4 no set on sense change", 4'h0, 32'h0);
    @(negedge clk); src_in[10] = 1'b0;
    settle();
    rd_chk("R4 falling edge latched", 4'h0, bit_of(10));
    wr(4'h0, bit_of(10));
    @(negedge clk); src_in[10] = 1'b1;
    settle();
    rd_chk("R4 rising edge ignored", 4'h0, 32'h0);
  endtask

  task automatic t_setwins();
    @(negedge clk); src_in[7] = 1'b1;
    repeat (2) @(negedge clk); src_in[7] = 1'b0;
    settle();
    rd_chk("R3 second pulse latched", 4'h0, bit_of(7));
    // New edge reaches the status flop on the 3rd edge after the input change
    @(negedge clk); src_in[7] = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); bus_addr = 4'h0; bus_wdata = bit_of(7); bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
    rd_chk("R7 set beats same-cycle ack", 4'h0, bit_of(7));
    wr(4'h0, bit_of(7));
    rd_chk("R7 later ack clears", 4'h0, 32'h0);
    @(negedge clk); src_in[7] = 1'b0;
    settle();
  endtask

  task automatic t_steer();
    wr(4'h3, bit_of(2));
    wr(4'h2, bit_of(2) | bit_of(5));
    @(negedge clk); src_in[5] = 1'b1;
    settle();
    chk("R9 only normal", {30'd0, norm_irq, crit_irq}, 32'h2);
    chk("R10 source 5 alone", {26'd0, pend_valid, pend_src}, {26'd0, 1'b1, 5'd5});
    @(negedge clk); src_in[2] = 1'b1;
    settle();
    chk("R9 both outputs", {30'd0, norm_irq, crit_irq}, 32'h3);
    chk("R10 lowest wins", {26'd0, pend_valid, pend_src}, {26'd0, 1'b1, 5'd2});
    wr(4'h2, bit_of(5));
    settle();
    chk("R9 critical drops when masked", {30'd0, norm_irq, crit_irq}, 32'h2);
    chk("R10 moves to source 5", {26'd0, pend_valid, pend_src}, {26'd0, 1'b1, 5'd5});
  endtask

  task automatic t_holes();
    rd_chk("R11 offset 1", 4'h1, 32'h0);
    rd_chk("R11 offset 7", 4'h7, 32'h0);
    rd_chk("R11 offset 8", 4'h8, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    t_reset();
    t_level();
    t_edge();
    t_fall();
    t_setwins();
    t_steer();
    t_holes();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule